// File: doc/BRIEF.md
# Posit Result Encoder with Tapered Rounding

This block is the last stage of a posit arithmetic pipeline. An upstream operator hands it an exact result in unpacked form: a sign, a signed binary scale, the fraction bits that follow the hidden one, a sticky flag for anything already discarded, and two flags for the special values. The encoder turns these into one `NBITS`-wide posit word with `ES` exponent bits, registered one cycle after a valid input.

The regime is a run whose length depends on the scale, so the number of fraction bits that fit in the word changes with the magnitude of the value. The encoder builds the regime run and the exponent bits, then places the fraction below them. It rounds the tail that falls off the end to nearest even. A carry out of the fraction moves up into the exponent and regime. The result saturates at the largest and smallest positive posits rather than turning into NaR or zero. Negative results are the two's complement of the positive word.

Top module: `posit_encoder`

## Requirements
- R1: A word offered with `inValid` high appears on `outPosit` with `outValid` high on the next clock. `outValid` is low one clock after `inValid` is low, and `outPosit` then keeps its previous value.
- R2: When `inIsNar` is set, the output is NaR: a one in the top bit and zeros in all other bits. This takes priority over `inIsZero`.
- R3: When `inIsZero` is set and `inIsNar` is clear, the output is all zeros.
- R4: The regime value k is `inScale` shifted right arithmetically by `ES`. For k >= 0 the regime field is k+1 ones followed by a zero. For k < 0 it is -k zeros followed by a one. The field starts just below the sign bit and is followed by the low `ES` bits of `inScale`.
- R5: The fraction bits from `inFrac` fill the bits left below the exponent, most significant bit first (the top bit of `inFrac` weighs one half). The number kept shrinks as the regime grows longer.
- R6: The dropped tail is rounded to nearest, ties to even. The guard bit is the first dropped bit. The sticky term is the OR of the later dropped bits and `inSticky`.
- R7: A rounding carry that ripples out of the fraction increments the exponent and the regime correctly.
- R8: A scale above (NBITS-2)*2^ES, or a rounding that would pass the largest value, gives maxpos (0 followed by all ones).
- R9: A scale below -(NBITS-2)*2^ES gives minpos (all zeros but the last bit). A value that is not flagged never encodes as zero or NaR.
- R10: When `inSign` is set, the output is the two's complement of the word the positive value would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word is valid this cycle |
| inSign | input | 1 | Sign of the result, 1 = negative |
| inScale | input | SCALE_W | Signed power-of-two scale of the result |
| inFrac | input | FRAC_W | Fraction bits below the hidden one, MSB first |
| inSticky | input | 1 | OR of bits discarded before this stage |
| inIsNar | input | 1 | Force the NaR output |
| inIsZero | input | 1 | Force the zero output |
| outValid | output | 1 | Output word is valid |
| outPosit | output | NBITS | Encoded posit |

## Verification
The case that is hardest to reach is a round-up carry that runs through every kept fraction bit and the exponent, and changes the regime length. It needs the exponent and all the kept fraction bits at one, with a guard bit set. The stimulus gets there by choosing the scale first, which fixes where the rounding point lies, and then setting the fraction so that all bits above that point are ones. The same method places ties exactly on the guard bit at two regime lengths. This shows that the rounding point moves. The saturation edges are approached from both sides with scales just inside and far outside the representable range.

// File: rtl/posit_encoder_pkg.sv
package posit_encoder_pkg;
  // Strobes from control to datapath for one output update.
  typedef struct packed {
    logic load;     // capture a new word into the output register
    logic selNar;   // override with NaR
    logic selZero;  // override with zero
  } encStrobe_t;
endpackage

// File: rtl/posit_encoder_ctrl.sv
module posit_encoder_ctrl
  import posit_encoder_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inIsNar,
  input  logic       inIsZero,
  output encStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.load    = inValid;
    strobe.selNar  = inIsNar;
    strobe.selZero = inIsZero & ~inIsNar;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/posit_encoder_dp.sv
module posit_encoder_dp
  import posit_encoder_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int ES      = 1,
  parameter int FRAC_W  = 8,
  parameter int SCALE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  encStrobe_t                strobe,
  input  logic                      inSign,
  input  logic signed [SCALE_W-1:0] inScale,
  input  logic [FRAC_W-1:0]         inFrac,
  input  logic                      inSticky,
  output logic [NBITS-1:0]          outPosit
);
  localparam int TW      = ES + FRAC_W;        // exponent plus fraction
  localparam int MW      = NBITS - 1;          // magnitude bits below sign
  localparam int VW      = NBITS + 2 + TW;     // shift window
  localparam int SHW     = $clog2(NBITS) + 1;
  localparam int MAX_REG = NBITS - 2;
  localparam int MAX_SCL = MAX_REG * (1 << ES);
  localparam logic [NBITS-1:0] NAR_WORD = {1'b1, {(NBITS-1){1'b0}}};

  logic [TW-1:0] tail;
  generate
    if (ES > 0) begin : g_exp
      assign tail = {inScale[ES-1:0], inFrac};
    end else begin : g_noexp
      assign tail = inFrac;
    end
  endgenerate

  int scaleInt, regimeInt;
  logic satHi, satLo, regNeg;
  logic [SHW-1:0] posAmt, negAmt;
  logic [VW-1:0] vPos, vNeg, shifted;
  logic [MW-1:0] keep, mag;
  logic guardBit, stickyAll, roundUp;
  logic [NBITS-1:0] word, signedWord;

  always_comb begin
    scaleInt  = int'(inScale);
    regimeInt = scaleInt >>> ES;
    satHi     = scaleInt > MAX_SCL;
    satLo     = scaleInt < -MAX_SCL;
    regNeg    = regimeInt < 0;
    posAmt    = regNeg ? '0 : SHW'(regimeInt);
    negAmt    = regNeg ? SHW'(-regimeInt - 1) : '0;
    // Positive regime: ones shifted in from the top; negative: zeros.
    vPos      = {2'b10, tail, {NBITS{1'b0}}};
    vNeg      = {2'b01, tail, {NBITS{1'b0}}};
    shifted   = regNeg ? (vNeg >> negAmt) : VW'($signed(vPos) >>> posAmt);
    keep      = shifted[VW-1 -: MW];
    guardBit  = shifted[VW-1-MW];
    stickyAll = (|shifted[VW-2-MW:0]) | inSticky;
    // Nearest-even; never carry past maxpos.
    roundUp   = guardBit & (keep[0] | stickyAll) & ~(&keep);
    mag       = keep + MW'(roundUp);
    if (satHi)      mag = {MW{1'b1}};
    else if (satLo) mag = MW'(1);
    word       = {1'b0, mag};
    signedWord = inSign ? (~word + NBITS'(1)) : word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outPosit <= '0;
    end else if (strobe.load) begin
      if (strobe.selNar)       outPosit <= NAR_WORD;
      else if (strobe.selZero) outPosit <= '0;
      else                     outPosit <= signedWord;
    end
  end
endmodule

// File: rtl/posit_encoder.sv
module posit_encoder
  import posit_encoder_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int ES      = 1,
  parameter int FRAC_W  = 8,
  parameter int SCALE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  input  logic                      inSign,
  input  logic signed [SCALE_W-1:0] inScale,
  input  logic [FRAC_W-1:0]         inFrac,
  input  logic                      inSticky,
  input  logic                      inIsNar,
  input  logic                      inIsZero,
  output logic                      outValid,
  output logic [NBITS-1:0]          outPosit
);
  encStrobe_t strobe;

  posit_encoder_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inIsNar(inIsNar),
    .inIsZero(inIsZero), .strobe(strobe), .outValid(outValid)
  );

  posit_encoder_dp #(
    .NBITS(NBITS), .ES(ES), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inSign(inSign),
    .inScale(inScale), .inFrac(inFrac), .inSticky(inSticky),
    .outPosit(outPosit)
  );
endmodule

// File: rtl/posit_encoder_chk.sv
module posit_encoder_chk #(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             inSign,
  input logic             inIsNar,
  input logic             inIsZero,
  input logic             outValid,
  input logic [NBITS-1:0] outPosit
);
  localparam logic [NBITS-1:0] NAR_WORD = {1'b1, {(NBITS-1){1'b0}}};

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(outPosit)));
  // R2
  nar_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inIsNar) |=> outPosit == NAR_WORD);
  // R3
  zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inIsZero && !inIsNar) |=> outPosit == '0);
  // R9
  no_collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !inIsZero && !inIsNar) |=> (outPosit != '0 && outPosit != NAR_WORD));
  // R10
  sign_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !inIsZero && !inIsNar) |=> outPosit[NBITS-1] == $past(inSign));
endmodule

bind posit_encoder posit_encoder_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSign(inSign),
  .inIsNar(inIsNar), .inIsZero(inIsZero), .outValid(outValid),
  .outPosit(outPosit)
);

// File: tb/tb_posit_encoder.sv
module tb_posit_encoder;
  localparam int NBITS = 8, ES = 1, FRAC_W = 8, SCALE_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inValid = 1'b0, inSign = 1'b0, inSticky = 1'b0;
  logic inIsNar = 1'b0, inIsZero = 1'b0;
  logic signed [SCALE_W-1:0] inScale = '0;
  logic [FRAC_W-1:0] inFrac = '0;
  logic outValid;
  logic [NBITS-1:0] outPosit;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  posit_encoder #(.NBITS(NBITS), .ES(ES), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSign(inSign),
    .inScale(inScale), .inFrac(inFrac), .inSticky(inSticky),
    .inIsNar(inIsNar), .inIsZero(inIsZero), .outValid(outValid),
    .outPosit(outPosit)
  );

  task automatic check(input string req, input logic [NBITS-1:0] act,
                       input logic [NBITS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic encode(input string req, input logic s, input int scl,
                        input logic [FRAC_W-1:0] f, input logic st,
                        input logic nar, input logic zr,
                        input logic [NBITS-1:0] exp);
    @(negedge clk);
    inValid = 1'b1; inSign = s; inScale = SCALE_W'(scl); inFrac = f;
    inSticky = st; inIsNar = nar; inIsZero = zr;
    @(negedge clk);
    inValid = 1'b0;
    check(req, {7'd0, outValid}, 8'd1);
    check(req, outPosit, exp);
  endtask

  task automatic test_reset;
    check("R1 reset valid", {7'd0, outValid}, 8'd0);
    check("R1 reset word", outPosit, 8'h00);
  endtask

  task automatic test_regime;
    encode("R4 one", 0, 0, 8'h00, 0, 0, 0, 8'h40);
    encode("R4 two", 0, 1, 8'h00, 0, 0, 0, 8'h50);
    encode("R4 four", 0, 2, 8'h00, 0, 0, 0, 8'h60);
    encode("R4 quarter", 0, -2, 8'h00, 0, 0, 0, 8'h20);
    encode("R5 one_half_frac", 0, 0, 8'h80, 0, 0, 0, 8'h48);
  endtask

  task automatic test_round;
    encode("R6 tie_even_down", 0, 0, 8'h08, 0, 0, 0, 8'h40);
    encode("R6 tie_odd_up", 0, 0, 8'h18, 0, 0, 0, 8'h42);
    encode("R6 sticky_up", 0, 0, 8'h08, 1, 0, 0, 8'h41);
    encode("R5 short_frac_tie", 0, 4, 8'h20, 0, 0, 0, 8'h70);
    encode("R5 short_frac_up", 0, 4, 8'h60, 0, 0, 0, 8'h72);
    encode("R5 long_frac_exact", 0, 0, 8'h20, 0, 0, 0, 8'h42);
  endtask

  task automatic test_carry;
    encode("R7 carry_into_regime", 0, 1, 8'hF8, 0, 0, 0, 8'h60);
  endtask

  task automatic test_saturate;
    encode("R8 maxpos_edge", 0, 12, 8'hFF, 1, 0, 0, 8'h7F);
    encode("R8 maxpos_far", 0, 20, 8'h00, 0, 0, 0, 8'h7F);
    encode("R9 minpos_edge", 0, -12, 8'h00, 0, 0, 0, 8'h01);
    encode("R9 minpos_far", 0, -30, 8'hFF, 1, 0, 0, 8'h01);
    encode("R9 near_min_round", 0, -11, 8'h00, 0, 0, 0, 8'h02);
  endtask

  task automatic test_sign;
    encode("R10 minus_one", 1, 0, 8'h00, 0, 0, 0, 8'hC0);
    encode("R10 minus_maxpos", 1, 20, 8'h00, 0, 0, 0, 8'h81);
    encode("R10 minus_one_half", 1, 0, 8'h80, 0, 0, 0, 8'hB8);
  endtask

  task automatic test_special;
    encode("R2 nar", 0, 3, 8'h55, 0, 1, 0, 8'h80);
    encode("R2 nar_over_zero", 1, 0, 8'h00, 0, 1, 1, 8'h80);
    encode("R3 zero", 1, 5, 8'hAA, 1, 0, 1, 8'h00);
  endtask

  task automatic test_idle;
    encode("R1 load", 0, 0, 8'h80, 0, 0, 0, 8'h48);
    @(negedge clk);
    inScale = 8'sd7; inFrac = 8'hFF; inSign = 1'b1;
    @(negedge clk);
    check("R1 idle valid low", {7'd0, outValid}, 8'd0);
    check("R1 idle holds word", outPosit, 8'h48);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_regime();
    test_round();
    test_carry();
    test_saturate();
    test_sign();
    test_special();
    test_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule